// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block turns one command slot's scatter-gather descriptor table into a stream of (address, length) segments for a data mover. Given a command-list base and a slot number it locates the slot's 32-byte header and reads the descriptor count from it. Given the command-table base it then fetches descriptors one by one, starting at a caller-supplied entry index. Each descriptor yields one segment whose length is its 22-bit count field plus one. The last segment is cut short when the requested transfer length runs out.

A single burst emits at most `MAX_SEG` segments. Any descriptors beyond that cap are reported as left over, together with the index to resume from, so a later burst can continue the same command. The caller passes the bytes already done, and the block reports the device offset as base offset plus bytes done. When no descriptors are left over, the block writes the total bytes moved back into the header's byte-count word. Memory reads use a request held until a response strobe. The data copy and the command decode lie outside the block.

Top module: `sg_walker`

## Requirements
- R1: The slot header sits at `clb_base + slot*32`; its first word carries the descriptor count in bits [31:16], and the byte-count writeback targets header address + 4. A read request holds its address until `rd_valid`.
- R2: Descriptor i of the table lies at `ctba + 0x80 + i*16`. Word 0 holds the low address half and word 1 the high half. Word 3 holds the count in bits [21:0], and bits [31:22] of that word are ignored. The segment length is count + 1 (range 1 to 0x400000).
- R3: The walk emits segments in table order. It stops after the last descriptor of the burst or when the remaining length reaches zero, whichever comes first. The final segment is truncated to the remaining byte count.
- R4: When more than `MAX_SEG` descriptors remain from the start index, exactly `MAX_SEG` segments are emitted (unless length runs out first), and `entries_left` reports the excess.
- R5: A burst starts at descriptor index `seek`. `next_entry` reports `seek` plus the number of segments emitted, and `dev_offset` equals `base_off + done_bytes`.
- R6: `done` pulses for one cycle at the end of a walk, with `bytes_moved` equal to the bytes of this burst. When `entries_left` is zero, `wr_en` pulses in the same cycle with `wr_data = done_bytes + bytes_moved`; otherwise no write occurs.
- R7: A table with zero descriptors, a `seek` at or beyond the descriptor count, or a zero `xfer_len` completes with no segment and zero bytes moved.
- R8: After reset `busy`, `rd_req`, `seg_valid`, `wr_en` and `done` are low.
- R9: A `start` pulse while `busy` is high is ignored and leaves the ongoing walk's results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| clb_base | input | AW | Command-list base address |
| slot | input | SLOT_W | Command slot number |
| ctba | input | AW | Command-table base address |
| xfer_len | input | LW | Bytes requested for this burst |
| seek | input | CNT_W | First descriptor index of this burst |
| done_bytes | input | LW | Bytes completed by earlier bursts |
| base_off | input | AW | Device base offset |
| rd_req | output | 1 | Memory read request, held until response |
| rd_addr | output | AW | Byte address of the 32-bit word read |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 32 | Read response word |
| seg_valid | output | 1 | Segment strobe |
| seg_addr | output | AW | Segment buffer address |
| seg_len | output | LW | Segment length in bytes |
| wr_en | output | 1 | Byte-count writeback strobe |
| wr_addr | output | AW | Writeback address |
| wr_data | output | LW | Writeback value |
| done | output | 1 | Walk finished (one cycle) |
| busy | output | 1 | Walk in progress |
| bytes_moved | output | LW | Bytes emitted in this burst |
| entries_left | output | CNT_W | Descriptors beyond the burst cap |
| next_entry | output | CNT_W | Index to resume from |
| dev_offset | output | AW | Base offset plus bytes done |

## Verification
The bench builds the walker with `MAX_SEG` = 4 instead of the default 8. With that value a six-descriptor table hits the cap and the resumed second burst can be checked in a few hundred cycles. The address width stays at 64 bits, so descriptors with nonzero upper address words and a count word with junk in bits [31:22] exercise the full address assembly and the field mask. The 32-bit length still reaches the largest segment of 0x400000 bytes.

// File: rtl/sg_pkg.sv
package sg_pkg;
  // Header stride 32 bytes, descriptor stride 16 bytes
  localparam int unsigned HDR_SHIFT   = 5;
  localparam int unsigned ENT_SHIFT   = 4;
  // Descriptor table starts this many bytes into the command table
  localparam int unsigned TBL_BASE    = 128;
  // Width of the per-descriptor count field
  localparam int unsigned CNT_FIELD_W = 22;
  // Descriptor count lives in the upper half of header word 0
  localparam int unsigned HDR_CNT_LSB = 16;
  // Byte-count word offset within the header
  localparam int unsigned WB_OFS      = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_LO,
    ST_HI,
    ST_CNT,
    ST_FIN
  } walk_st_e;

  // Word index inside a descriptor
  localparam logic [1:0] DW_ADDR_LO = 2'd0;
  localparam logic [1:0] DW_ADDR_HI = 2'd1;
  localparam logic [1:0] DW_COUNT   = 2'd3;
endpackage

// File: rtl/sg_addr_calc.sv
module sg_addr_calc
  import sg_pkg::*;
#(
  parameter int AW     = 64,
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic [AW-1:0]     list_base,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [AW-1:0]     tbl_base,
  input  logic [CNT_W-1:0]  ent_idx,
  input  logic [1:0]        dw_sel,
  output logic [AW-1:0]     hdr_addr,
  output logic [AW-1:0]     ent_addr
);
  assign hdr_addr = list_base + (AW'(slot_num) << HDR_SHIFT);
  assign ent_addr = tbl_base + AW'(TBL_BASE) + (AW'(ent_idx) << ENT_SHIFT)
                  + (AW'(dw_sel) << 2);
endmodule

// File: rtl/sg_burst_plan.sv
module sg_burst_plan #(
  parameter int CNT_W   = 16,
  parameter int MAX_SEG = 8
) (
  input  logic [CNT_W-1:0] tbl_cnt,
  input  logic [CNT_W-1:0] first_idx,
  output logic [CNT_W-1:0] burst_n,
  output logic [CNT_W-1:0] spill_n
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_SEG);

  logic [CNT_W-1:0] avail;

  always_comb begin
    avail = (tbl_cnt > first_idx) ? (tbl_cnt - first_idx) : '0;
    if (avail > CAP) begin
      burst_n = CAP;
      spill_n = avail - CAP;
    end else begin
      burst_n = avail;
      spill_n = '0;
    end
  end
endmodule

// File: rtl/sg_seg_trim.sv
module sg_seg_trim
  import sg_pkg::*;
#(
  parameter int LW = 32
) (
  input  logic [31:0]   cnt_word,
  input  logic [LW-1:0] remain,
  output logic [LW-1:0] seg_len,
  output logic          drains
);
  logic [LW-1:0] full_len;

  always_comb begin
    full_len = LW'(cnt_word[CNT_FIELD_W-1:0]) + LW'(1);
    drains   = (full_len >= remain);
    seg_len  = drains ? remain : full_len;
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sg_pkg::*;
#(
  parameter int AW      = 64,
  parameter int LW      = 32,
  parameter int SLOT_W  = 5,
  parameter int CNT_W   = 16,
  parameter int MAX_SEG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     clb_base,
  input  logic [SLOT_W-1:0] slot,
  input  logic [AW-1:0]     ctba,
  input  logic [LW-1:0]     xfer_len,
  input  logic [CNT_W-1:0]  seek,
  input  logic [LW-1:0]     done_bytes,
  input  logic [AW-1:0]     base_off,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              seg_valid,
  output logic [AW-1:0]     seg_addr,
  output logic [LW-1:0]     seg_len,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [LW-1:0]     wr_data,
  output logic              done,
  output logic              busy,
  output logic [LW-1:0]     bytes_moved,
  output logic [CNT_W-1:0]  entries_left,
  output logic [CNT_W-1:0]  next_entry,
  output logic [AW-1:0]     dev_offset
);
  walk_st_e         state_q, state_d;
  logic [AW-1:0]    hdr_q, hdr_d, tbl_q, tbl_d, dev_q, dev_d;
  logic [CNT_W-1:0] idx_q, idx_d, cnt_q, cnt_d, left_q, left_d;
  logic [LW-1:0]    rem_q, rem_d, moved_q, moved_d, dbase_q, dbase_d;
  logic [31:0]      lo_q, lo_d, hi_q, hi_d;
  logic             segv_q, segv_d, wren_q, wren_d, done_q, done_d;
  logic [AW-1:0]    sega_q, sega_d, wra_q, wra_d;
  logic [LW-1:0]    segl_q, segl_d, wrd_q, wrd_d;

  logic [1:0]       dw_sel;
  logic [AW-1:0]    hdr_addr, ent_addr;
  logic [CNT_W-1:0] burst_n, spill_n;
  logic [LW-1:0]    trim_len;
  logic             drains;

  always_comb begin
    unique case (state_q)
      ST_HI:   dw_sel = DW_ADDR_HI;
      ST_CNT:  dw_sel = DW_COUNT;
      default: dw_sel = DW_ADDR_LO;
    endcase
  end

  sg_addr_calc #(.AW(AW), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_addr (
    .list_base (clb_base),
    .slot_num  (slot),
    .tbl_base  (tbl_q),
    .ent_idx   (idx_q),
    .dw_sel    (dw_sel),
    .hdr_addr  (hdr_addr),
    .ent_addr  (ent_addr)
  );

  sg_burst_plan #(.CNT_W(CNT_W), .MAX_SEG(MAX_SEG)) u_plan (
    .tbl_cnt   (CNT_W'(rd_data[31:HDR_CNT_LSB])),
    .first_idx (idx_q),
    .burst_n   (burst_n),
    .spill_n   (spill_n)
  );

  sg_seg_trim #(.LW(LW)) u_trim (
    .cnt_word (rd_data),
    .remain   (rem_q),
    .seg_len  (trim_len),
    .drains   (drains)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    hdr_d   = hdr_q;
    tbl_d   = tbl_q;
    dev_d   = dev_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    rem_d   = rem_q;
    moved_d = moved_q;
    dbase_d = dbase_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    sega_d  = sega_q;
    segl_d  = segl_q;
    wra_d   = wra_q;
    wrd_d   = wrd_q;
    segv_d  = 1'b0;
    wren_d  = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          hdr_d   = hdr_addr;
          tbl_d   = ctba;
          idx_d   = seek;
          rem_d   = xfer_len;
          moved_d = '0;
          left_d  = '0;
          dbase_d = done_bytes;
          dev_d   = base_off + AW'(done_bytes);
          state_d = ST_HDR;
        end
      end
      ST_HDR: begin
        if (rd_valid) begin
          cnt_d   = burst_n;
          left_d  = spill_n;
          state_d = (burst_n == '0 || rem_q == '0) ? ST_FIN : ST_LO;
        end
      end
      ST_LO: begin
        if (rd_valid) begin
          lo_d    = rd_data;
          state_d = ST_HI;
        end
      end
      ST_HI: begin
        if (rd_valid) begin
          hi_d    = rd_data;
          state_d = ST_CNT;
        end
      end
      ST_CNT: begin
        if (rd_valid) begin
          segv_d  = 1'b1;
          sega_d  = AW'({hi_q, lo_q});
          segl_d  = trim_len;
          rem_d   = rem_q - trim_len;
          moved_d = moved_q + trim_len;
          idx_d   = idx_q + CNT_W'(1);
          cnt_d   = cnt_q - CNT_W'(1);
          state_d = (cnt_q == CNT_W'(1) || drains) ? ST_FIN : ST_LO;
        end
      end
      ST_FIN: begin
        done_d  = 1'b1;
        wren_d  = (left_q == '0);
        wra_d   = hdr_q + AW'(WB_OFS);
        wrd_d   = dbase_q + moved_q;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      tbl_q   <= '0;
      dev_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      left_q  <= '0;
      rem_q   <= '0;
      moved_q <= '0;
      dbase_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      sega_q  <= '0;
      segl_q  <= '0;
      wra_q   <= '0;
      wrd_q   <= '0;
      segv_q  <= 1'b0;
      wren_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hdr_q   <= hdr_d;
      tbl_q   <= tbl_d;
      dev_q   <= dev_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
      rem_q   <= rem_d;
      moved_q <= moved_d;
      dbase_q <= dbase_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      sega_q  <= sega_d;
      segl_q  <= segl_d;
      wra_q   <= wra_d;
      wrd_q   <= wrd_d;
      segv_q  <= segv_d;
      wren_q  <= wren_d;
      done_q  <= done_d;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign rd_req       = (state_q == ST_HDR) || (state_q == ST_LO) ||
                        (state_q == ST_HI)  || (state_q == ST_CNT);
  assign rd_addr      = (state_q == ST_HDR) ? hdr_q : ent_addr;
  assign seg_valid    = segv_q;
  assign seg_addr     = sega_q;
  assign seg_len      = segl_q;
  assign wr_en        = wren_q;
  assign wr_addr      = wra_q;
  assign wr_data      = wrd_q;
  assign done         = done_q;
  assign bytes_moved  = moved_q;
  assign entries_left = left_q;
  assign next_entry   = idx_q;
  assign dev_offset   = dev_q;
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int AW      = 64,
  parameter int LW      = 32,
  parameter int CNT_W   = 16,
  parameter int MAX_SEG = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             rd_req,
  input logic [AW-1:0]    rd_addr,
  input logic             rd_valid,
  input logic             seg_valid,
  input logic [LW-1:0]    seg_len,
  input logic             wr_en,
  input logic             done,
  input logic [CNT_W-1:0] entries_left
);
  logic [31:0] seg_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seg_seen <= '0;
    else if (start && !busy)   seg_seen <= '0;
    else if (seg_valid)        seg_seen <= seg_seen + 32'd1;
  end

  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != '0));

  assert_seg_in_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> busy);

  assert_burst_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_seen < 32'(MAX_SEG)));

  assert_wb_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (done && entries_left == '0));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sg_walker sg_walker_chk #(
  .AW(AW), .LW(LW), .CNT_W(CNT_W), .MAX_SEG(MAX_SEG)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .rd_req       (rd_req),
  .rd_addr      (rd_addr),
  .rd_valid     (rd_valid),
  .seg_valid    (seg_valid),
  .seg_len      (seg_len),
  .wr_en        (wr_en),
  .done         (done),
  .entries_left (entries_left)
);

// File: tb/tb_sg_walker.sv
module tb_sg_walker;
  localparam int AW = 64, LW = 32, SLOT_W = 5, CNT_W = 16, MAX_SEG = 4;

  logic clk, rst_n, start;
  logic [AW-1:0] clb_base, ctba, base_off;
  logic [SLOT_W-1:0] slot;
  logic [LW-1:0] xfer_len, done_bytes;
  logic [CNT_W-1:0] seek;
  logic rd_req, rd_valid;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data;
  logic seg_valid, wr_en, done, busy;
  logic [AW-1:0] seg_addr, wr_addr, dev_offset;
  logic [LW-1:0] seg_len, wr_data, bytes_moved;
  logic [CNT_W-1:0] entries_left, next_entry;

  int n_cmp = 0;
  int n_bad = 0;

  sg_walker #(.AW(AW), .LW(LW), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .MAX_SEG(MAX_SEG)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clb_base(clb_base), .slot(slot),
    .ctba(ctba), .xfer_len(xfer_len), .seek(seek), .done_bytes(done_bytes),
    .base_off(base_off), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .busy(busy),
    .bytes_moved(bytes_moved), .entries_left(entries_left), .next_entry(next_entry),
    .dev_offset(dev_offset)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Memory model: one-cycle response, word-addressed by byte address
  logic [31:0] mem [longint];
  logic [63:0] ent_a [16];
  logic [31:0] ent_w [16];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req && !rd_valid;
      rd_data  <= mem.exists(longint'(rd_addr)) ? mem[longint'(rd_addr)] : 32'h0;
    end
  end

  // Reference expectation
  logic [63:0] q_addr [$];
  longint      q_len  [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Every clock: segments are compared against the reference queue
  always @(negedge clk) begin
    if (rst_n && seg_valid) begin
      if (q_addr.size() == 0) begin
        chk(1'b0, "R3", "unexpected segment", longint'(seg_len), 0);
      end else begin
        logic [63:0] ea;
        longint el;
        ea = q_addr.pop_front();
        el = q_len.pop_front();
        chk(seg_addr == ea, "R2", "segment address", longint'(seg_addr), longint'(ea));
        chk(longint'(seg_len) == el, "R3", "segment length", longint'(seg_len), el);
      end
    end
  end

  task automatic put_hdr(input longint clb, input int s, input int cnt);
    mem[clb + s * 32] = {cnt[15:0], 16'h00A5};
    mem[clb + s * 32 + 4] = 32'hFFFF_FFFF;
  endtask

  task automatic put_ent(input longint tb, input int i, input logic [63:0] a,
                         input logic [31:0] w);
    mem[tb + 128 + i * 16]      = a[31:0];
    mem[tb + 128 + i * 16 + 4]  = a[63:32];
    mem[tb + 128 + i * 16 + 8]  = 32'hDEAD_BEEF;
    mem[tb + 128 + i * 16 + 12] = w;
    ent_a[i] = a;
    ent_w[i] = w;
  endtask

  task automatic run(input longint clb, input int s, input longint tb, input int cnt,
                     input longint len, input int sk, input longint dbytes,
                     input longint boff, input bit poke, output longint moved_o);
    int avail, iov, left, emitted, waited;
    longint rem, moved;
    bit got;
    avail = (cnt > sk) ? cnt - sk : 0;
    iov   = (avail > MAX_SEG) ? MAX_SEG : avail;
    left  = avail - iov;
    rem = len; moved = 0; emitted = 0;
    while (emitted < iov && rem > 0) begin
      longint full;
      full = longint'(ent_w[sk + emitted] & 32'h003F_FFFF) + 1;
      if (full > rem) full = rem;
      q_addr.push_back(ent_a[sk + emitted]);
      q_len.push_back(full);
      rem -= full; moved += full; emitted++;
    end
    moved_o = moved;

    @(negedge clk);
    clb_base = AW'(clb); slot = SLOT_W'(s); ctba = AW'(tb); xfer_len = LW'(len);
    seek = CNT_W'(sk); done_bytes = LW'(dbytes); base_off = AW'(boff); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      clb_base = 64'h7777_0000; slot = 5'd31; ctba = 64'h9999_0000;
      xfer_len = 32'd1; seek = 16'd0; done_bytes = 32'd5; base_off = 64'h1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 1'b0; waited = 0;
    while (!got && waited < 1000) begin
      if (done) got = 1'b1;
      else begin
        if (wr_en) chk(1'b0, "R6", "writeback without done", 1, 0);
        @(negedge clk);
        waited++;
      end
    end
    chk(got, "R6", "done reached", longint'(got), 1);
    if (got) begin
      chk(q_addr.size() == 0, "R3", "segments outstanding", q_addr.size(), 0);
      chk(longint'(bytes_moved) == moved, "R6", "bytes_moved",
          longint'(bytes_moved), moved);
      chk(int'(entries_left) == left, "R4", "entries_left", longint'(entries_left), left);
      chk(int'(next_entry) == sk + emitted, "R5", "next_entry",
          longint'(next_entry), sk + emitted);
      chk(dev_offset == AW'(boff + dbytes), "R5", "dev_offset",
          longint'(dev_offset), boff + dbytes);
      chk(wr_en == (left == 0), "R6", "writeback strobe", longint'(wr_en), left == 0);
      if (left == 0) begin
        chk(wr_addr == AW'(clb + s * 32 + 4), "R1", "writeback address",
            longint'(wr_addr), clb + s * 32 + 4);
        chk(longint'(wr_data) == dbytes + moved, "R6", "writeback value",
            longint'(wr_data), dbytes + moved);
      end
      @(negedge clk);
      chk(!done && !busy, "R6", "done single cycle", longint'(done), 0);
    end
    q_addr.delete();
    q_len.delete();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    longint m1, m2;
    start = 1'b0; clb_base = '0; slot = '0; ctba = '0; xfer_len = '0;
    seek = '0; done_bytes = '0; base_off = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle after reset
    chk(!busy && !rd_req && !seg_valid && !wr_en && !done, "R8", "reset outputs",
        {busy, rd_req, seg_valid, wr_en, done}, 0);

    // R1 R2 R6: three full descriptors, plenty of length
    mem.delete();
    put_hdr(64'h1000, 0, 3);
    put_ent(64'h8000, 0, 64'h0000_0000_4000_0000, 32'h0000_00FF);
    put_ent(64'h8000, 1, 64'h0000_0000_4000_1000, 32'h0000_01FF);
    put_ent(64'h8000, 2, 64'h0000_0000_4000_2000, 32'h0000_03FF);
    run(64'h1000, 0, 64'h8000, 3, 4096, 0, 0, 0, 1'b0, m1);

    // R3 R1: slot 5, high address words, last segment truncated
    mem.delete();
    put_hdr(64'h0000_0002_0000_0000, 5, 2);
    put_ent(64'h0000_0003_0000_0400, 0, 64'h0000_0001_2345_6000, 32'h0000_00FF);
    put_ent(64'h0000_0003_0000_0400, 1, 64'h0000_00AB_0000_8000, 32'h0000_01FF);
    run(64'h0000_0002_0000_0000, 5, 64'h0000_0003_0000_0400, 2, 600, 0, 0, 64'h100,
        1'b0, m1);

    // R2: junk in bits above the count field; largest count
    mem.delete();
    put_hdr(64'h1000, 2, 2);
    put_ent(64'h8000, 0, 64'h5000, 32'hFFC0_0010);
    put_ent(64'h8000, 1, 64'h6000, 32'h003F_FFFF);
    run(64'h1000, 2, 64'h8000, 2, 64'h0100_0000, 0, 0, 0, 1'b0, m1);

    // R3: length runs out exactly at the end of descriptor 1
    mem.delete();
    put_hdr(64'h1000, 1, 3);
    for (int i = 0; i < 3; i++) put_ent(64'h8000, i, 64'h7000 + i * 64'h100, 32'h0000_00FF);
    run(64'h1000, 1, 64'h8000, 3, 512, 0, 0, 0, 1'b0, m1);

    // R4 R5: six descriptors, capped burst then resume
    mem.delete();
    put_hdr(64'h3000, 3, 6);
    for (int i = 0; i < 6; i++)
      put_ent(64'hA000, i, 64'h0000_0010_0000_0000 + i * 64'h1_0000, 32'(i * 16 + 15));
    run(64'h3000, 3, 64'hA000, 6, 100000, 0, 0, 64'h20000, 1'b0, m1);
    run(64'h3000, 3, 64'hA000, 6, 100000 - m1, 4, m1, 64'h20000, 1'b0, m2);

    // R7: empty table, seek past end, zero length
    mem.delete();
    put_hdr(64'h1000, 4, 0);
    run(64'h1000, 4, 64'h8000, 0, 4096, 0, 0, 0, 1'b0, m1);
    put_hdr(64'h1000, 4, 3);
    for (int i = 0; i < 3; i++) put_ent(64'h8000, i, 64'hB000 + i * 64'h40, 32'h3F);
    run(64'h1000, 4, 64'h8000, 3, 4096, 3, 77, 0, 1'b0, m1);
    run(64'h1000, 4, 64'h8000, 3, 0, 0, 0, 0, 1'b0, m1);

    // R9: a second start during the walk changes nothing
    run(64'h1000, 4, 64'h8000, 3, 4096, 0, 0, 64'h55, 1'b1, m1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule